// File: doc/BRIEF.md
# Strobed Watchdog Timer with Timeout Write Lock

This block is a down-counting watchdog that advances on a slow periodic tick (nominally 32 Hz, one tick every 31.25 ms). A host controls it through one byte-wide control register. That register holds three things: a strobe bit, a lock bit and a 6-bit timeout value counted in ticks. The usable timeout range is 1 tick up to 63 ticks, which is about two seconds at 32 Hz. A timeout value of zero turns the watchdog off.

When the host writes the strobe bit, the counter is reloaded on the next tick and counting starts again. If the count reaches zero before another strobe arrives, the block emits a one-clock timeout pulse, which feeds the flag and interrupt logic outside the block. The lock bit protects the timeout field. While the lock is set, the host can keep strobing without rewriting the timeout value.

The tick source and the flag register are outside this block. Ticks count only while the oscillator enable input is high.

Top module: `wdog_strobe`

## Requirements
- R1: After reset the register reads back `{1'b0, 1'b0, INIT_TMO}` and counting starts from INIT_TMO. With no strobe, the timeout pulse follows the INIT_TMO-th enabled tick.
- R2: Writing a byte with bit 7 = 1 (strobe) makes the next enabled tick reload the counter from the timeout field. The timeout pulse then follows the (timeout+1)-th enabled tick counted from the write. Strobing again before expiry prevents the pulse.
- R3: Bit 7 always reads back as 0. A write with bit 7 = 0 does not change the running count.
- R4: Bit 6 (lock) takes the written value on every write. If the lock was 1 before a write, the timeout field (bits 5:0) keeps its value.
- R5: If the lock was 0 before a write, that write stores bits 5:0 as the new timeout, even when the same write sets the lock.
- R6: A newly stored timeout does not alter a count already running. It is first used by the reload on the next enabled tick after a strobe.
- R7: A timeout field of 0 disables the watchdog. The counter rests at zero and no pulse is produced, however many ticks arrive.
- R8: While osc_en is 0, ticks are ignored: no decrement, no reload, and a pending strobe stays pending.
- R9: The timeout pulse lasts exactly one clock. After a timeout the counter stays at zero and no further pulse occurs until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse at the watchdog tick rate |
| osc_en | input | 1 | Oscillator running; ticks are ignored while low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 7 strobe, bit 6 lock, bits 5:0 timeout |
| rd_data | output | 8 | Register read-back; bit 7 reads as 0 |
| timeout_pulse | output | 1 | One-clock pulse when the count reaches zero |

## Verification
Read-back changes on the clock edge that accepts the write, so the bench samples it at the following falling edge. A strobe takes effect only at the next enabled tick. After that reload, the timeout pulse is registered one clock after the tick edge that moves the count from one to zero. The bench therefore drives each tick as a single-clock pulse followed by an idle clock, and counts pulses at falling edges. Pulse counts are compared after exact tick numbers: one tick before the expected expiry, and at the expiry itself.

// File: rtl/wdog_strobe.sv
module wdog_strobe #(
  parameter int TMO_W = 6,
  parameter logic [TMO_W-1:0] INIT_TMO = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             osc_en,
  input  logic             wr_en,
  input  logic [TMO_W+1:0] wr_data,
  output logic [TMO_W+1:0] rd_data,
  output logic             timeout_pulse
);

  localparam int STB_BIT  = TMO_W + 1;
  localparam int LOCK_BIT = TMO_W;

  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] cnt_q;
  logic             lock_q;
  logic             pend_q;
  logic             pulse_q;

  wire tk      = tick & osc_en;
  wire wr_stb  = wr_en & wr_data[STB_BIT];
  wire off     = (tmo_q == '0);
  wire expire  = tk & ~pend_q & ~off & (cnt_q == TMO_W'(1));

  assign rd_data       = {1'b0, lock_q, tmo_q};
  assign timeout_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= INIT_TMO;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      lock_q <= wr_data[LOCK_BIT];
      if (!lock_q) tmo_q <= wr_data[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (wr_stb) begin
      pend_q <= 1'b1;
    end else if (tk) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT_TMO;
    end else if (tk) begin
      if (pend_q)            cnt_q <= tmo_q;
      else if (off)          cnt_q <= '0;
      else if (cnt_q != '0)  cnt_q <= cnt_q - TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= expire;
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_pulse_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $past(tick && osc_en));

  assert_osc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(cnt_q));

  assert_locked_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_q) |=> $stable(tmo_q));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && !pend_q && off) |=> (cnt_q == '0) && !timeout_pulse);

  assert_rest_after_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !pend_q && !wr_stb) |=> cnt_q == '0);

  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && pend_q && !wr_stb) |=> (cnt_q == $past(tmo_q)) && !pend_q);

endmodule

// File: tb/wdog_strobe_bench.sv
module wdog_strobe_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       osc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       timeout_pulse;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdog_strobe #(.TMO_W(6), .INIT_TMO(6'd5)) u_wdog_strobe (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_en(osc_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .timeout_pulse(timeout_pulse)
  );

  always @(negedge clk) if (rst_n && timeout_pulse) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic expect_pulses(input int base, input int n, input string req);
    check(pulses - base == n, req, pulses - base, n);
  endtask

  task automatic t_reset;
    int b;
    check(rd_data == 8'h05, "R1", rd_data, 8'h05);
    check(timeout_pulse == 1'b0, "R1", timeout_pulse, 0);
    b = pulses;
    ticks(4);
    expect_pulses(b, 0, "R1");
    ticks(1);
    expect_pulses(b, 1, "R1");
    ticks(5);
    expect_pulses(b, 1, "R9");
  endtask

  task automatic t_strobe;
    int b;
    wr(8'h85);
    check(rd_data == 8'h05, "R3", rd_data, 8'h05);
    b = pulses;
    ticks(5);
    expect_pulses(b, 0, "R2");
    ticks(1);
    expect_pulses(b, 1, "R2");
    ticks(6);
    expect_pulses(b, 1, "R9");
  endtask

  task automatic t_zero_strobe;
    int b;
    wr(8'h85);
    b = pulses;
    ticks(3);
    wr(8'h05);
    ticks(2);
    expect_pulses(b, 0, "R3");
    ticks(1);
    expect_pulses(b, 1, "R3");
  endtask

  task automatic t_kick;
    int b;
    b = pulses;
    for (int k = 0; k < 4; k++) begin
      wr(8'h85);
      ticks(4);
    end
    expect_pulses(b, 0, "R2");
  endtask

  task automatic t_new_value;
    int b;
    wr(8'h85);
    b = pulses;
    ticks(2);
    wr(8'h03);
    check(rd_data == 8'h03, "R5", rd_data, 8'h03);
    ticks(3);
    expect_pulses(b, 0, "R6");
    ticks(1);
    expect_pulses(b, 1, "R6");
    wr(8'h83);
    b = pulses;
    ticks(3);
    expect_pulses(b, 0, "R6");
    ticks(1);
    expect_pulses(b, 1, "R6");
  endtask

  task automatic t_disable;
    int b;
    wr(8'h80);
    check(rd_data == 8'h00, "R7", rd_data, 0);
    b = pulses;
    ticks(70);
    expect_pulses(b, 0, "R7");
    wr(8'h82);
    ticks(3);
    expect_pulses(b, 1, "R7");
  endtask

  task automatic t_osc;
    int b;
    wr(8'h84);
    osc_en = 1'b0;
    b = pulses;
    ticks(12);
    expect_pulses(b, 0, "R8");
    osc_en = 1'b1;
    ticks(4);
    expect_pulses(b, 0, "R8");
    ticks(1);
    expect_pulses(b, 1, "R8");
  endtask

  task automatic t_lock;
    int b;
    wr(8'h4A);
    check(rd_data == 8'h4A, "R5", rd_data, 8'h4A);
    wr(8'h45);
    check(rd_data == 8'h4A, "R4", rd_data, 8'h4A);
    wr(8'hC1);
    check(rd_data == 8'h4A, "R4", rd_data, 8'h4A);
    b = pulses;
    ticks(10);
    expect_pulses(b, 0, "R4");
    ticks(1);
    expect_pulses(b, 1, "R4");
    wr(8'h07);
    check(rd_data == 8'h0A, "R4", rd_data, 8'h0A);
    wr(8'h07);
    check(rd_data == 8'h07, "R5", rd_data, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_strobe;
    t_zero_strobe;
    t_kick;
    t_new_value;
    t_disable;
    t_osc;
    t_lock;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule